// File: doc/BRIEF.md
# Command Response Capture FIFO

This block sits between a memory-card host's register file and its card-side serializer. Software loads a 6-bit command index and a 32-bit argument, written as two 16-bit halves, and selects a response type. It then issues the command. The block presents the index and argument to the card side and collects the response bytes that come back. It checks the byte count against the length the response type requires, and packs the bytes into a response FIFO of 16-bit words that software drains one word per pop.

Every issued command raises a sticky end-of-command request. It also raises exactly one of two statuses: done when enough bytes arrived, or timeout when too few arrived. When the response succeeds and the data enable was selected, a one-cycle pulse starts the data phase. Each issue also sends a one-cycle flush pulse to the data FIFOs and clears the pending-command flag.

Top module: `cmd_resp_capture`

## Requirements
- R1: With response type 0 (no response), the cycle after `issue` shows `st_done`=1, `end_req`=1 and `busy`=0, and no bytes are awaited.
- R2: Types 1 and 3 need at least 4 bytes and type 2 needs at least 16. A response that ends with fewer bytes sets `st_timeout`, leaves `st_done` low and gives no `data_start` pulse. `st_done` and `st_timeout` are never high together.
- R3: On success, response byte 2i lands in bits 7:0 of word i and byte 2i+1 lands in bits 15:8.
- R4: `resp_word` shows the word at the read pointer. Each `pop` advances the pointer by one. A successful response resets the pointer to word 0. Once all 9 words have been popped, `resp_word` reads 0.
- R5: Every `issue` clears all response words to zero. After a timeout, every word reads 0.
- R6: `end_req` is set when any command finishes, whether it completed or timed out, and stays set until `end_clr` is pulsed.
- R7: `cmd_idx` holds the last 6-bit index written. `idx_rd` returns that index with bit 6 set.
- R8: `arg_hi_wr` loads argument bits 31:16 and `arg_lo_wr` loads bits 15:0. Each write leaves the other half unchanged. `arg_hi_rd` and `arg_lo_rd` return the matching halves.
- R9: A config write sets `pend`. An `issue` clears `pend` and produces a one-cycle `flush` pulse in the following cycle.
- R10: A successful completion with the data enable selected gives a one-cycle `data_start` pulse in the same cycle that `st_done` rises.
- R11: `busy` rises the cycle after an `issue` of types 1 to 3. It falls the cycle after the byte marked `rsp_last` is accepted.
- R12: Bytes beyond the 18th are counted for the length check, but they do not change the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load response type and data enable |
| cfg_type | input | 2 | Response type 0..3 |
| cfg_data_en | input | 1 | Start a data phase after success |
| idx_wr | input | 1 | Load command index |
| idx_data | input | 6 | Command index |
| arg_hi_wr | input | 1 | Load argument bits 31:16 |
| arg_lo_wr | input | 1 | Load argument bits 15:0 |
| arg_wdata | input | 16 | Argument half |
| issue | input | 1 | Start a command |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |
| pop | input | 1 | Advance the response read pointer |
| end_clr | input | 1 | Clear the end-of-command request |
| resp_word | output | 16 | Word at the read pointer |
| idx_rd | output | 7 | Index readback with bit 6 set |
| arg_hi_rd | output | 16 | Argument bits 31:16 |
| arg_lo_rd | output | 16 | Argument bits 15:0 |
| cmd_idx | output | 6 | Index to the card side |
| cmd_arg | output | 32 | Argument to the card side |
| pend | output | 1 | Command configured, not yet issued |
| busy | output | 1 | Awaiting response bytes |
| st_done | output | 1 | Response completed |
| st_timeout | output | 1 | Response too short |
| end_req | output | 1 | Sticky end-of-command request |
| flush | output | 1 | One-cycle data FIFO flush |
| data_start | output | 1 | One-cycle data phase start |

## Verification
The hardest case to reach from the ports is an over-long response. Such a response passes the length check, but the bytes past the 18th must not disturb any stored word. The stimulus sends 20 bytes on a type-2 command, drains all nine words plus one extra pop, and expects the final read to be zero. Boundary counts are covered as well: 3 and then exactly 4 bytes on type 3, and 10 bytes on type 2. Each timeout that follows a full capture shows that the words were cleared.

// File: rtl/cmd_resp_capture.sv
module cmd_resp_capture #(
  parameter int NWORDS = 9,
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_type,
  input  logic               cfg_data_en,
  input  logic               idx_wr,
  input  logic [IDX_W-1:0]   idx_data,
  input  logic               arg_hi_wr,
  input  logic               arg_lo_wr,
  input  logic [ARG_W/2-1:0] arg_wdata,
  input  logic               issue,
  input  logic               rsp_valid,
  input  logic [7:0]         rsp_byte,
  input  logic               rsp_last,
  input  logic               pop,
  input  logic               end_clr,
  output logic [15:0]        resp_word,
  output logic [IDX_W:0]     idx_rd,
  output logic [ARG_W/2-1:0] arg_hi_rd,
  output logic [ARG_W/2-1:0] arg_lo_rd,
  output logic [IDX_W-1:0]   cmd_idx,
  output logic [ARG_W-1:0]   cmd_arg,
  output logic               pend,
  output logic               busy,
  output logic               st_done,
  output logic               st_timeout,
  output logic               end_req,
  output logic               flush,
  output logic               data_start
);
  localparam int HALF   = ARG_W / 2;
  localparam int NBYTES = 2 * NWORDS;
  localparam int PW     = $clog2(NWORDS + 1);
  localparam int CW     = $clog2(NBYTES) + 2;

  logic [15:0]     words [NWORDS];
  logic [1:0]      cfg_type_q, cur_type;
  logic            cfg_den_q, cur_den;
  logic [CW-1:0]   cnt, need_len;
  logic [PW-1:0]   rd_ptr;
  logic [IDX_W-1:0] idx_q;
  logic [ARG_W-1:0] arg_q;

  assign need_len  = (cur_type == 2'd2) ? CW'(16) : CW'(4);
  assign resp_word = (rd_ptr < PW'(NWORDS)) ? words[rd_ptr] : 16'h0;
  assign idx_rd    = {1'b1, idx_q};
  assign cmd_idx   = idx_q;
  assign cmd_arg   = arg_q;
  assign arg_hi_rd = arg_q[ARG_W-1:HALF];
  assign arg_lo_rd = arg_q[HALF-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_type_q <= '0; cur_type <= '0; cfg_den_q <= 1'b0; cur_den <= 1'b0;
      cnt <= '0; rd_ptr <= '0; idx_q <= '0; arg_q <= '0;
      pend <= 1'b0; busy <= 1'b0; st_done <= 1'b0; st_timeout <= 1'b0;
      end_req <= 1'b0; flush <= 1'b0; data_start <= 1'b0;
      for (int i = 0; i < NWORDS; i++) words[i] <= '0;
    end else begin
      flush      <= 1'b0;
      data_start <= 1'b0;
      if (cfg_wr) begin
        cfg_type_q <= cfg_type;
        cfg_den_q  <= cfg_data_en;
        pend       <= 1'b1;
      end
      if (idx_wr)    idx_q <= idx_data;
      if (arg_hi_wr) arg_q[ARG_W-1:HALF] <= arg_wdata;
      if (arg_lo_wr) arg_q[HALF-1:0] <= arg_wdata;
      if (end_clr)   end_req <= 1'b0;
      if (pop && rd_ptr < PW'(NWORDS)) rd_ptr <= rd_ptr + 1'b1;

      if (issue) begin
        pend       <= 1'b0;
        flush      <= 1'b1;
        cnt        <= '0;
        rd_ptr     <= '0;
        st_done    <= 1'b0;
        st_timeout <= 1'b0;
        cur_type   <= cfg_type_q;
        cur_den    <= cfg_den_q;
        for (int i = 0; i < NWORDS; i++) words[i] <= '0;
        if (cfg_type_q == 2'd0) begin
          busy       <= 1'b0;
          st_done    <= 1'b1;
          end_req    <= 1'b1;
          data_start <= cfg_den_q;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy && rsp_valid) begin
        for (int i = 0; i < NWORDS; i++) begin
          if (cnt == CW'(2 * i))     words[i][7:0]  <= rsp_byte;
          if (cnt == CW'(2 * i + 1)) words[i][15:8] <= rsp_byte;
        end
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (rsp_last) begin
          busy    <= 1'b0;
          end_req <= 1'b1;
          if (cnt >= need_len - 1'b1) begin
            st_done    <= 1'b1;
            rd_ptr     <= '0;
            data_start <= cur_den;
          end else begin
            st_timeout <= 1'b1;
            for (int i = 0; i < NWORDS; i++) words[i] <= '0;
          end
        end
      end
    end
  end
endmodule

module cmd_resp_capture_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic             idx_wr,
  input logic [IDX_W-1:0] idx_data,
  input logic [IDX_W:0]   idx_rd,
  input logic             rsp_valid,
  input logic             rsp_last,
  input logic [15:0]      resp_word,
  input logic             busy,
  input logic             st_done,
  input logic             st_timeout,
  input logic             end_req,
  input logic             flush,
  input logic             pend
);
  a_r2_done_xor_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_done && st_timeout));
  a_r6_end_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> end_req && (st_done || st_timeout));
  a_r9_flush_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> flush && !pend);
  a_r11_last_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_valid && rsp_last && !issue |=> !busy);
  a_r5_timeout_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st_timeout && !busy |-> resp_word == 16'h0);
  a_r7_index_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_rd[IDX_W-1:0] == $past(idx_data) && idx_rd[IDX_W]);
  a_r1_issue_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !st_timeout);
endmodule

bind cmd_resp_capture cmd_resp_capture_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .idx_wr(idx_wr), .idx_data(idx_data),
  .idx_rd(idx_rd), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
  .resp_word(resp_word), .busy(busy), .st_done(st_done),
  .st_timeout(st_timeout), .end_req(end_req), .flush(flush), .pend(pend)
);

// File: tb/tb_cmd_resp_capture.sv
module tb_cmd_resp_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_data_en = 0, idx_wr = 0, arg_hi_wr = 0, arg_lo_wr = 0;
  logic issue = 0, rsp_valid = 0, rsp_last = 0, pop = 0, end_clr = 0;
  logic [1:0]  cfg_type = 0;
  logic [5:0]  idx_data = 0;
  logic [15:0] arg_wdata = 0;
  logic [7:0]  rsp_byte = 0;
  logic [15:0] resp_word, arg_hi_rd, arg_lo_rd;
  logic [6:0]  idx_rd;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic pend, busy, st_done, st_timeout, end_req, flush, data_start;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  cmd_resp_capture dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] t, input logic den);
    @(negedge clk); cfg_wr = 1; cfg_type = t; cfg_data_en = den;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic do_issue();
    @(negedge clk); issue = 1;
    @(negedge clk); issue = 0;
  endtask

  task automatic send(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rsp_valid = 1; rsp_byte = base + 8'(i); rsp_last = (i == n - 1);
    end
    @(negedge clk); rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic push_expected(input int n, input logic [7:0] base);
    for (int i = 0; i < 9; i++)
      if (2 * i + 1 < n) exp_q.push_back({base + 8'(2 * i + 1), base + 8'(2 * i)});
      else if (2 * i < n) exp_q.push_back({8'h00, base + 8'(2 * i)});
      else exp_q.push_back(16'h0);
    exp_q.push_back(16'h0);
  endtask

  task automatic push_zeros();
    for (int i = 0; i < 10; i++) exp_q.push_back(16'h0);
  endtask

  task automatic monitor(input string req);
    while (exp_q.size() > 0) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(req, resp_word, e);
      pop = 1;
      @(negedge clk); pop = 0;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset status", {st_done, st_timeout, end_req, pend}, 0);
    chk("R7 reset idx_rd", idx_rd, 7'h40);
    chk("R4 reset resp_word", resp_word, 0);

    @(negedge clk); idx_wr = 1; idx_data = 6'h2A;
    @(negedge clk); idx_wr = 0;
    chk("R7 idx_rd", idx_rd, 7'h6A);
    chk("R7 cmd_idx", cmd_idx, 6'h2A);
    @(negedge clk); arg_hi_wr = 1; arg_wdata = 16'h1234;
    @(negedge clk); arg_hi_wr = 0; arg_lo_wr = 1; arg_wdata = 16'hABCD;
    @(negedge clk); arg_lo_wr = 0;
    chk("R8 arg_hi_rd", arg_hi_rd, 16'h1234);
    chk("R8 arg_lo_rd", arg_lo_rd, 16'hABCD);
    chk("R8 cmd_arg", cmd_arg, 32'h1234ABCD);

    configure(2'd1, 1'b1);
    chk("R9 pend set", pend, 1);
    do_issue();
    chk("R9 flush", flush, 1);
    chk("R9 pend cleared", pend, 0);
    chk("R11 busy", busy, 1);
    send(6, 8'h11);
    chk("R11 busy fell", busy, 0);
    chk("R10 data_start", data_start, 1);
    chk("R2 done type1", {st_done, st_timeout}, 2'b10);
    chk("R6 end_req", end_req, 1);
    @(negedge clk);
    chk("R10 data_start one cycle", data_start, 0);
    push_expected(6, 8'h11);
    monitor("R3 R4 type1 words");

    @(negedge clk); end_clr = 1;
    @(negedge clk); end_clr = 0;
    chk("R6 end_clr", end_req, 0);

    configure(2'd2, 1'b1);
    do_issue();
    send(10, 8'h80);
    chk("R2 type2 short timeout", {st_done, st_timeout}, 2'b01);
    chk("R2 no data_start", data_start, 0);
    chk("R6 end_req after timeout", end_req, 1);
    push_zeros();
    monitor("R5 timeout zeros");

    do_issue();
    send(20, 8'h40);
    chk("R12 type2 long done", st_done, 1);
    push_expected(18, 8'h40);
    monitor("R12 R4 words beyond 18 ignored");

    configure(2'd0, 1'b0);
    @(negedge clk); issue = 1;
    @(negedge clk); issue = 0;
    chk("R1 type0 done", {st_done, busy, end_req}, 3'b101);
    chk("R1 no data_start", data_start, 0);
    push_zeros();
    monitor("R5 cleared at issue");

    configure(2'd3, 1'b0);
    do_issue();
    send(3, 8'hC0);
    chk("R2 type3 three bytes", {st_done, st_timeout}, 2'b01);
    do_issue();
    send(4, 8'hD0);
    chk("R2 type3 four bytes", {st_done, st_timeout}, 2'b10);
    push_expected(4, 8'hD0);
    monitor("R3 type3 words");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule